// File: doc/BRIEF.md
# Self-Checking Dual-Rail Equality Tree

This block decides whether two N-bit words are equal when every bit of each word travels on a complementary pair of wires. Each bit position has its own small comparator cell. A balanced tree of merge nodes reduces the cell results to one verdict, and that verdict is also a complementary pair. If the pair is complementary, it is the answer: "equal" or "different". If the pair is not complementary (both rails low or both rails high), one of two things has happened. Either an operand pair was corrupted, or a single line inside the tree is stuck. A downstream monitor therefore never has to trust a silent answer. Any modelled defect either leaves the result correct or shows up as an illegal verdict.

Each merge node is built from AND/OR logic that is unate in every rail. A single stuck line can push its own rail in only one direction, so the fault either does not change the result or turns the verdict into an illegal pair. The tree width N is rounded up to a power of two. Unused leaves are tied to the "equal" verdict. For verification, a fault port can force any one internal rail to a chosen constant. An optional output register, selected by a parameter, gives the verdict one cycle of latency.

Top module: `dr_cmp_tree`

## Requirements
- R1: Operand bit i is legal when its true rail and false rail differ. The pattern true=1/false=0 means logic 1 and true=0/false=1 means logic 0.
- R2: With all operand pairs legal and no forced rail, the output is res_diff=1, res_eq=0 when the words differ in any bit. It is res_diff=0, res_eq=1 when they are identical.
- R3: If exactly one operand pair is illegal (00 or 11) and every other bit position holds equal legal values, the output is illegal (res_diff equal to res_eq).
- R4: res_err is 1 exactly when res_diff equals res_eq.
- R5: While flt_en is 0, the values of flt_sel and flt_val have no effect on the outputs.
- R6: With legal operands and any single forced rail, the output is either the correct legal verdict or an illegal pair.
- R7: For every rail index from 2 to 4*P-1 and each forced value, at least one legal operand pattern produces an illegal output.
- R8: Node k of the tree has children 2k and 2k+1, with node 1 as the root and the leaf for bit i at node P+i, where P is N rounded up to a power of two. flt_sel = 2k selects the equal rail of node k and flt_sel = 2k+1 selects its differ rail.
- R9: With REG_OUT=1, the verdict appears one clock after the operands. A synchronous reset sets the output to res_diff=0, res_eq=1.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| a_t | input | N | True rails of operand A |
| a_f | input | N | False rails of operand A |
| b_t | input | N | True rails of operand B |
| b_f | input | N | False rails of operand B |
| flt_en | input | 1 | Enables forcing of one internal rail |
| flt_sel | input | SELW | Index of the forced rail (see R8) |
| flt_val | input | 1 | Constant driven onto the selected rail |
| res_diff | output | 1 | Differ rail of the verdict |
| res_eq | output | 1 | Equal rail of the verdict |
| res_err | output | 1 | High when the verdict pair is illegal |

## Verification
The bench runs a four-bit tree exhaustively over all legal operand pairs. It also puts each illegal pair pattern on every bit position, with the remaining bits matched. A tree whose merge node let a differing sibling mask everything would hide those illegal pairs, and a leaf that decoded the rails backwards would report equal words as different.

Every internal rail is then forced to 0 and to 1 across all 256 operand pairs. Each forced run must never yield a wrong legal verdict, and must show an illegal verdict at least once. A merge formula that lost monotonicity would fail the first condition. A rail that no input could expose would fail the second.

Further checks cover the disabled fault port, the rail numbering, the register latency and the reset value.

// File: rtl/dr_cmp_pkg.sv
package dr_cmp_pkg;

    // One logical bit carried on two complementary wires.
    typedef struct packed {
        logic tr;
        logic fl;
    } rail_t;

    // A comparison verdict, also a complementary pair.
    typedef struct packed {
        logic dif;
        logic eq;
    } verdict_t;

    localparam verdict_t VERDICT_SAME = '{dif: 1'b0, eq: 1'b1};

    // Leaf: differ when the true rail of one operand meets the false rail of the other.
    function automatic verdict_t leaf_cmp(rail_t a, rail_t b);
        verdict_t v;
        v.dif = (a.tr & b.fl) | (a.fl & b.tr);
        v.eq  = (a.tr & b.tr) | (a.fl & b.fl);
        return v;
    endfunction

    // Merge: monotone in each rail so that a stuck line only moves toward non-code.
    function automatic verdict_t merge_cmp(verdict_t l, verdict_t r);
        verdict_t v;
        v.dif = l.dif | r.dif;
        v.eq  = l.eq & r.eq;
        return v;
    endfunction

endpackage

// File: rtl/dr_cmp_leaf.sv
module dr_cmp_leaf
    import dr_cmp_pkg::*;
(
    input  rail_t    op_a,
    input  rail_t    op_b,
    output verdict_t vout
);
    assign vout = leaf_cmp(op_a, op_b);
endmodule

// File: rtl/dr_cmp_node.sv
module dr_cmp_node
    import dr_cmp_pkg::*;
(
    input  verdict_t lhs,
    input  verdict_t rhs,
    output verdict_t vout
);
    assign vout = merge_cmp(lhs, rhs);
endmodule

// File: rtl/dr_fault_tap.sv
module dr_fault_tap #(
    parameter int IDX  = 2,
    parameter int SELW = 4
) (
    input  logic            raw,
    input  logic            en,
    input  logic [SELW-1:0] sel,
    input  logic            val,
    output logic            line
);
    localparam logic [SELW-1:0] MY_SEL = SELW'(IDX);
    assign line = (en && (sel == MY_SEL)) ? val : raw;
endmodule

// File: rtl/dr_cmp_tree.sv
module dr_cmp_tree
    import dr_cmp_pkg::*;
#(
    parameter  int N       = 8,
    parameter  bit REG_OUT = 1'b1,
    localparam int P       = 1 << $clog2(N),
    localparam int SELW    = $clog2(4 * P)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    a_t,
    input  logic [N-1:0]    a_f,
    input  logic [N-1:0]    b_t,
    input  logic [N-1:0]    b_f,
    input  logic            flt_en,
    input  logic [SELW-1:0] flt_sel,
    input  logic            flt_val,
    output logic            res_diff,
    output logic            res_eq,
    output logic            res_err
);
    localparam int NODES = 2 * P - 1;

    // Heap-ordered rails: node k, children 2k and 2k+1, leaves at P..2P-1.
    logic [NODES:1] dif_raw, eq_raw;
    logic [NODES:1] dif_q, eq_q;

    // Leaves, with padding tied to the equal verdict.
    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_real
            verdict_t lv;
            dr_cmp_leaf u_leaf (
                .op_a('{tr: a_t[i], fl: a_f[i]}),
                .op_b('{tr: b_t[i], fl: b_f[i]}),
                .vout(lv)
            );
            assign dif_raw[P+i] = lv.dif;
            assign eq_raw[P+i]  = lv.eq;
        end else begin : g_pad
            assign dif_raw[P+i] = VERDICT_SAME.dif;
            assign eq_raw[P+i]  = VERDICT_SAME.eq;
        end
    end

    // Internal merge nodes.
    for (genvar k = 1; k < P; k++) begin : g_node
        verdict_t nv;
        dr_cmp_node u_node (
            .lhs ('{dif: dif_q[2*k],   eq: eq_q[2*k]}),
            .rhs ('{dif: dif_q[2*k+1], eq: eq_q[2*k+1]}),
            .vout(nv)
        );
        assign dif_raw[k] = nv.dif;
        assign eq_raw[k]  = nv.eq;
    end

    // Fault taps on every node output rail: index 2k is eq, 2k+1 is dif.
    for (genvar k = 1; k <= NODES; k++) begin : g_tap
        dr_fault_tap #(.IDX(2*k), .SELW(SELW)) u_tap_eq (
            .raw(eq_raw[k]), .en(flt_en), .sel(flt_sel), .val(flt_val), .line(eq_q[k])
        );
        dr_fault_tap #(.IDX(2*k+1), .SELW(SELW)) u_tap_dif (
            .raw(dif_raw[k]), .en(flt_en), .sel(flt_sel), .val(flt_val), .line(dif_q[k])
        );
    end

    // Output stage.
    if (REG_OUT) begin : g_reg
        verdict_t held;
        always_ff @(posedge clk) begin
            if (rst) held <= VERDICT_SAME;
            else     held <= '{dif: dif_q[1], eq: eq_q[1]};
        end
        assign res_diff = held.dif;
        assign res_eq   = held.eq;
    end else begin : g_comb
        assign res_diff = dif_q[1];
        assign res_eq   = eq_q[1];
    end

    assign res_err = ~(res_diff ^ res_eq);

endmodule

// File: rtl/dr_cmp_tree_chk.sv
module dr_cmp_tree_chk #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1,
    parameter int SELW    = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    a_t,
    input logic [N-1:0]    a_f,
    input logic [N-1:0]    b_t,
    input logic [N-1:0]    b_f,
    input logic            flt_en,
    input logic [SELW-1:0] flt_sel,
    input logic            flt_val,
    input logic            res_diff,
    input logic            res_eq,
    input logic            res_err
);
    logic all_code, one_bad, others_match, words_differ;
    assign all_code     = (&(a_t ^ a_f)) && (&(b_t ^ b_f));
    assign one_bad      = ($countones(~(a_t ^ a_f)) == 1) && (&(b_t ^ b_f));
    assign others_match = &((a_t ~^ b_t) | ~(a_t ^ a_f));
    assign words_differ = (a_t != b_t);

    if (REG_OUT) begin : g_seq
        // R2
        verdict_ok_chk: assert property (@(posedge clk) disable iff (rst)
            (all_code && !flt_en) |=> (res_diff == $past(words_differ)) && (res_eq != $past(words_differ)));
        // R3
        bad_input_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (one_bad && others_match && !flt_en) |=> res_err);
        // R6
        fault_secure_chk: assert property (@(posedge clk) disable iff (rst)
            all_code |=> (res_err || (res_diff == $past(words_differ))));
        // R9
        reset_value_chk: assert property (@(posedge clk)
            rst |=> (!res_diff && res_eq));
    end else begin : g_comb
        // R2
        verdict_ok_chk: assert property (@(posedge clk) disable iff (rst)
            (all_code && !flt_en) |-> (res_diff == words_differ) && (res_eq != words_differ));
        // R3
        bad_input_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (one_bad && others_match && !flt_en) |-> res_err);
        // R6
        fault_secure_chk: assert property (@(posedge clk) disable iff (rst)
            all_code |-> (res_err || (res_diff == words_differ)));
    end

    logic unused_ok;
    assign unused_ok = ^{flt_sel, flt_val};

endmodule

bind dr_cmp_tree dr_cmp_tree_chk #(.N(N), .REG_OUT(REG_OUT), .SELW(SELW)) u_chk (.*);

// File: tb/sim_dr_cmp_tree.sv
`timescale 1ns/1ps
module sim_dr_cmp_tree;
    localparam int N    = 4;
    localparam int P    = 4;
    localparam int SELW = 4;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] a_t, a_f, b_t, b_f;
    logic flt_en, flt_val;
    logic [SELW-1:0] flt_sel;
    logic res_diff, res_eq, res_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dr_cmp_tree #(.N(N), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .flt_en(flt_en), .flt_sel(flt_sel), .flt_val(flt_val),
        .res_diff(res_diff), .res_eq(res_eq), .res_err(res_err)
    );

    task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s diff/eq/err actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive_code(input logic [N-1:0] a, input logic [N-1:0] b);
        a_t = a; a_f = ~a; b_t = b; b_f = ~b;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [2:0] legal(input logic same);
        return same ? 3'b010 : 3'b100;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; flt_en = 1'b0; flt_sel = '0; flt_val = 1'b0;
        drive_code(4'h3, 4'hC);
        step();
        step();
        // R9: reset value
        check3("R9 reset", {res_diff, res_eq, res_err}, 3'b010);
        #2 rst = 1'b0;

        // R1 R2 R4 R5: all legal pairs, fault port disabled with moving select and value
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                drive_code(a[3:0], b[3:0]);
                flt_sel = 4'(a + b);
                flt_val = a[0] ^ b[1];
                step();
                check3("R1 R2 R4 R5 legal sweep", {res_diff, res_eq, res_err}, legal(a == b));
            end
        end

        // R3 R4: one illegal operand pair, remaining bits matched
        for (int j = 0; j < N; j++) begin
            for (int pat = 0; pat < 2; pat++) begin
                for (int a = 0; a < 16; a++) begin
                    drive_code(a[3:0], a[3:0]);
                    a_t[j] = pat[0];
                    a_f[j] = pat[0];
                    step();
                    check1("R3 illegal pair flagged", res_err, 1'b1);
                    check1("R4 err means rails agree", res_diff == res_eq, 1'b1);
                end
            end
        end

        // R6 R7: every rail forced to each value across all legal pairs
        flt_en = 1'b1;
        for (int w = 2; w < 4 * P; w++) begin
            for (int v = 0; v < 2; v++) begin
                automatic bit hit = 1'b0;
                flt_sel = 4'(w);
                flt_val = v[0];
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        drive_code(a[3:0], b[3:0]);
                        step();
                        if (res_err) hit = 1'b1;
                        else check3("R6 fault secure", {res_diff, res_eq, res_err}, legal(a == b));
                    end
                end
                check1($sformatf("R7 rail %0d stuck %0d exposed", w, v), hit, 1'b1);
            end
        end

        // R8: rail numbering, leaf of bit 2 is node 6, differ rail index 13
        flt_sel = 4'd13; flt_val = 1'b1;
        drive_code(4'h5, 4'h5);
        step();
        check3("R8 leaf bit2 dif forced on equal words", {res_diff, res_eq, res_err}, 3'b111);
        drive_code(4'h5, 4'h1);
        step();
        check3("R8 leaf bit2 dif forced, bit2 differs", {res_diff, res_eq, res_err}, 3'b100);
        drive_code(4'h5, 4'h7);
        step();
        check3("R8 leaf bit2 dif forced, bit1 differs", {res_diff, res_eq, res_err}, 3'b100);
        // R8: root equal rail index 2
        flt_sel = 4'd2; flt_val = 1'b1;
        drive_code(4'h9, 4'h8);
        step();
        check3("R8 root eq forced on different words", {res_diff, res_eq, res_err}, 3'b111);
        flt_en = 1'b0;

        // R9: one cycle latency
        drive_code(4'hA, 4'hA);
        step();
        check3("R9 settled equal", {res_diff, res_eq, res_err}, 3'b010);
        drive_code(4'hA, 4'hB);
        #3;
        check3("R9 no change before edge", {res_diff, res_eq, res_err}, 3'b010);
        step();
        check3("R9 change after edge", {res_diff, res_eq, res_err}, 3'b100);

        // R9: synchronous reset mid-run
        rst = 1'b1;
        step();
        check3("R9 sync reset", {res_diff, res_eq, res_err}, 3'b010);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule